// File: doc/BRIEF.md
# Delay-Line Phase Window Search Engine

This block finds the range of 6-bit delay-line phase codes for which a memory read path works, then picks the centre of that range. For each candidate code it raises an apply request so that an outside sequencer can program the delay line. After the acknowledge, it waits for a memory test to report pass or fail. It then updates a low bound and a high bound. When the search ends it pulses `done` and presents the centre code, together with a flag that says whether any passing window was found.

There are two search modes, chosen by `mode` when `start` is pulsed.

- **Sweep** (`mode`=0) tries every code from 0 up to 63. It records the first passing code as the low bound and the last passing code as the high bound.
- **Anchored** (`mode`=1) begins at a known-good `median` code. It first climbs one code at a time while tests pass. It then returns to the median and descends while tests pass.

Both bounds hold the sentinel 0xFFFF whenever no window has been recorded. A reported result of 0xFFFF means that no window exists.

The apply interface is a valid/ready pair. `apply_req` is the valid and `apply_ack` is the ready. While the acknowledge is held low, the request and its code stay asserted and unchanged, so the sequencer can stall the engine for any number of cycles. Only one code is outstanding at a time. The engine issues no new request until `test_done` has returned a verdict for the current code. `test_done` is a one-cycle strobe, and `test_pass` is sampled with it. A `start` pulse is accepted only while the engine is idle.

Top module: `phwin_search`

## Requirements
- R1: A synchronous reset, including one applied in the middle of a search, returns the block to idle. After reset `apply_req`=0, `done`=0, `found`=0, and `result`, `win_lo` and `win_hi` all equal 0xFFFF. No request is issued until the next `start`.
- R2: In sweep mode (`mode`=0) the engine requests exactly 64 codes, in the ascending order 0, 1, …, 63, whatever the test results.
- R3: In sweep mode a passing code loads `win_lo` only while `win_lo` still holds 0xFFFF, and it always loads `win_hi`. A failing code changes neither bound.
- R4: When no code passes in a sweep, `done` reports `found`=0 and `result`=0xFFFF.
- R5: In anchored mode (`mode`=1) both bounds start at `median` and the first code is `median`. Each pass loads `win_hi` and moves the code up by one. The upward phase ends at the first fail, or after code 63 has been tested.
- R6: The anchored downward phase starts again at `median`, which is retested. Each pass loads `win_lo` and moves the code down by one. The search ends at the first fail, or after code 0 has been tested.
- R7: When a window exists, `found`=1 and `result` = `win_lo` + ((`win_hi` − `win_lo`) >> 1).
- R8: `apply_req` stays high with a stable `apply_code` until `apply_ack` is seen. It drops in the cycle after the acknowledge and stays low until the test verdict for that code has arrived.
- R9: `done` is high for exactly one cycle, in the cycle after the final verdict is taken. `result` and `found` hold their values until the next search ends.
- R10: A `start` pulse that arrives while a search is running is ignored and has no effect on the sequence of codes or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a search (accepted only while idle) |
| mode | input | 1 | 0 = full sweep, 1 = anchored search |
| median | input | 6 | Anchor code for anchored mode |
| apply_req | output | 1 | Valid: program `apply_code` into the delay line |
| apply_code | output | 6 | Phase code to apply |
| apply_ack | input | 1 | Ready: the code has been applied |
| test_done | input | 1 | One-cycle strobe: the test verdict is available |
| test_pass | input | 1 | Verdict for the current code, sampled with `test_done` |
| done | output | 1 | One-cycle pulse at the end of a search |
| found | output | 1 | 1 when a passing window was found |
| result | output | 16 | Centre code, or 0xFFFF when there is no window |
| win_lo | output | 16 | Current low bound (0xFFFF if none) |
| win_hi | output | 16 | Current high bound (0xFFFF if none) |

## Verification
A wrong phase or code register in the controller shows up on `apply_code` at the very next request, as an out-of-order or repeated code. It also shows up at `done` as a wrong number of requests, which the bench counts against an independent model of the search. A bound that loads when it should not, such as a low bound overwritten during a sweep, is visible on `win_lo` and `win_hi`, which are held after `done`. Such a fault also pulls `result` away from the expected centre in the same cycle as `done`. Handshake faults, such as a dropped request, a code that changes under back-pressure, or a `done` that lasts more than one cycle, become visible within one cycle of the stall or pulse that exposes them.

// File: rtl/phwin_pkg.sv
package phwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_APPLY  = 2'd1,
    ST_TEST   = 2'd2,
    ST_FINISH = 2'd3
  } phw_state_e;

  typedef enum logic {
    MODE_SWEEP  = 1'b0,
    MODE_ANCHOR = 1'b1
  } phw_mode_e;

endpackage

// File: rtl/phwin_ctrl.sv
// Search sequencer: walks the phase code, runs the apply/test handshake
// and tells the bound registers when to load.
module phwin_ctrl
  import phwin_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] median_i,
  input  logic              apply_ack,
  input  logic              test_done,
  input  logic              test_pass,
  input  logic              lo_set,
  output logic              apply_req,
  output logic [CODE_W-1:0] code_o,
  output logic              init_sweep,
  output logic              init_anchor,
  output logic              upd_lo,
  output logic              upd_hi,
  output logic              finish
);

  localparam logic [CODE_W-1:0] CODE_TOP = '1;
  localparam logic [CODE_W-1:0] CODE_BOT = '0;

  phw_state_e        state_q, state_n;
  phw_mode_e         mode_q, mode_n;
  logic              down_q, down_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [CODE_W-1:0] med_q, med_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SWEEP;
      down_q  <= 1'b0;
      code_q  <= '0;
      med_q   <= '0;
    end else begin
      state_q <= state_n;
      mode_q  <= mode_n;
      down_q  <= down_n;
      code_q  <= code_n;
      med_q   <= med_n;
    end
  end

  always_comb begin
    state_n     = state_q;
    mode_n      = mode_q;
    down_n      = down_q;
    code_n      = code_q;
    med_n       = med_q;
    init_sweep  = 1'b0;
    init_anchor = 1'b0;
    upd_lo      = 1'b0;
    upd_hi      = 1'b0;
    finish      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mode_n  = phw_mode_e'(mode_i);
          med_n   = median_i;
          down_n  = 1'b0;
          state_n = ST_APPLY;
          if (mode_i) begin
            init_anchor = 1'b1;
            code_n      = median_i;
          end else begin
            init_sweep = 1'b1;
            code_n     = CODE_BOT;
          end
        end
      end
      ST_APPLY: begin
        if (apply_ack) state_n = ST_TEST;
      end
      ST_TEST: begin
        if (test_done) begin
          state_n = ST_APPLY;
          if (mode_q == MODE_SWEEP) begin
            // full range: fails simply advance
            if (test_pass) begin
              upd_hi = 1'b1;
              upd_lo = !lo_set;
            end
            if (code_q == CODE_TOP) state_n = ST_FINISH;
            else                    code_n  = code_q + 1'b1;
          end else if (!down_q) begin
            // climbing from the anchor
            if (test_pass) upd_hi = 1'b1;
            if (test_pass && code_q != CODE_TOP) begin
              code_n = code_q + 1'b1;
            end else begin
              down_n = 1'b1;
              code_n = med_q;
            end
          end else begin
            // descending from the anchor
            if (test_pass) upd_lo = 1'b1;
            if (test_pass && code_q != CODE_BOT) code_n  = code_q - 1'b1;
            else                                 state_n = ST_FINISH;
          end
        end
      end
      ST_FINISH: begin
        finish  = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign apply_req = (state_q == ST_APPLY);
  assign code_o    = code_q;

endmodule

// File: rtl/phwin_bounds.sv
// Low/high window bound registers with sentinel initialisation.
module phwin_bounds #(
  parameter int CODE_W  = 6,
  parameter int BOUND_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_sweep,
  input  logic               init_anchor,
  input  logic [CODE_W-1:0]  anchor,
  input  logic               upd_lo,
  input  logic               upd_hi,
  input  logic [CODE_W-1:0]  code,
  output logic [BOUND_W-1:0] lo,
  output logic [BOUND_W-1:0] hi,
  output logic               lo_set
);

  localparam int                 PAD  = BOUND_W - CODE_W;
  localparam logic [BOUND_W-1:0] SENT = '1;

  logic [BOUND_W-1:0] code_w, anchor_w;

  assign code_w   = {{PAD{1'b0}}, code};
  assign anchor_w = {{PAD{1'b0}}, anchor};

  always_ff @(posedge clk) begin
    if (rst || init_sweep) begin
      lo <= SENT;
      hi <= SENT;
    end else if (init_anchor) begin
      lo <= anchor_w;
      hi <= anchor_w;
    end else begin
      if (upd_lo) lo <= code_w;
      if (upd_hi) hi <= code_w;
    end
  end

  assign lo_set = (lo != SENT);

endmodule

// File: rtl/phwin_center.sv
// Midpoint of the recorded window; flags the no-window case.
module phwin_center #(
  parameter int BOUND_W = 16
) (
  input  logic [BOUND_W-1:0] lo,
  input  logic [BOUND_W-1:0] hi,
  output logic [BOUND_W-1:0] mid,
  output logic               empty
);

  localparam logic [BOUND_W-1:0] SENT = '1;

  logic [BOUND_W-1:0] span;

  assign empty = (lo == SENT) || (hi == SENT);
  assign span  = hi - lo;
  assign mid   = empty ? SENT : (lo + (span >> 1));

endmodule

// File: rtl/phwin_search.sv
module phwin_search #(
  parameter int CODE_W  = 6,
  parameter int BOUND_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               mode,
  input  logic [CODE_W-1:0]  median,
  output logic               apply_req,
  output logic [CODE_W-1:0]  apply_code,
  input  logic               apply_ack,
  input  logic               test_done,
  input  logic               test_pass,
  output logic               done,
  output logic               found,
  output logic [BOUND_W-1:0] result,
  output logic [BOUND_W-1:0] win_lo,
  output logic [BOUND_W-1:0] win_hi
);

  localparam logic [BOUND_W-1:0] SENT = '1;

  logic               init_sweep, init_anchor, upd_lo, upd_hi, finish, lo_set;
  logic [BOUND_W-1:0] mid;
  logic               empty;

  phwin_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode_i(mode), .median_i(median),
    .apply_ack(apply_ack), .test_done(test_done), .test_pass(test_pass),
    .lo_set(lo_set), .apply_req(apply_req), .code_o(apply_code),
    .init_sweep(init_sweep), .init_anchor(init_anchor),
    .upd_lo(upd_lo), .upd_hi(upd_hi), .finish(finish)
  );

  phwin_bounds #(.CODE_W(CODE_W), .BOUND_W(BOUND_W)) u_bounds (
    .clk(clk), .rst(rst), .init_sweep(init_sweep), .init_anchor(init_anchor),
    .anchor(median), .upd_lo(upd_lo), .upd_hi(upd_hi), .code(apply_code),
    .lo(win_lo), .hi(win_hi), .lo_set(lo_set)
  );

  phwin_center #(.BOUND_W(BOUND_W)) u_center (
    .lo(win_lo), .hi(win_hi), .mid(mid), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      found  <= 1'b0;
      result <= SENT;
    end else begin
      done <= finish;
      if (finish) begin
        found  <= !empty;
        result <= mid;
      end
    end
  end

endmodule

// File: rtl/phwin_search_chk.sv
module phwin_search_chk #(
  parameter int CODE_W  = 6,
  parameter int BOUND_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               apply_req,
  input logic [CODE_W-1:0]  apply_code,
  input logic               apply_ack,
  input logic               done,
  input logic               found,
  input logic [BOUND_W-1:0] result,
  input logic [BOUND_W-1:0] win_lo,
  input logic [BOUND_W-1:0] win_hi
);

  localparam logic [BOUND_W-1:0] SENT = '1;

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (apply_req && !apply_ack) |=> (apply_req && $stable(apply_code)));

  p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (apply_req && apply_ack) |=> !apply_req);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !apply_req);

  p_nowin_sent_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (result == SENT));

  p_mid_inside_r7: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> (result >= win_lo && result <= win_hi));

  p_bound_order_r5: assert property (@(posedge clk) disable iff (rst)
    (win_lo != SENT) |-> (win_hi != SENT && win_lo <= win_hi));

endmodule

bind phwin_search phwin_search_chk #(.CODE_W(CODE_W), .BOUND_W(BOUND_W)) u_chk (
  .clk(clk), .rst(rst), .apply_req(apply_req), .apply_code(apply_code),
  .apply_ack(apply_ack), .done(done), .found(found), .result(result),
  .win_lo(win_lo), .win_hi(win_hi)
);

// File: tb/phwin_search_tb_top.sv
`timescale 1ns/1ps
module phwin_search_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [5:0]  median = '0;
  logic        apply_req;
  logic [5:0]  apply_code;
  logic        apply_ack = 1'b0;
  logic        test_done = 1'b0;
  logic        test_pass = 1'b0;
  logic        done, found;
  logic [15:0] result, win_lo, win_hi;

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk = ~clk;

  phwin_search dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .median(median),
    .apply_req(apply_req), .apply_code(apply_code), .apply_ack(apply_ack),
    .test_done(test_done), .test_pass(test_pass), .done(done), .found(found),
    .result(result), .win_lo(win_lo), .win_hi(win_hi)
  );

  typedef struct packed {
    logic        md;
    logic [5:0]  med;
    logic [5:0]  a_lo, a_hi, b_lo, b_hi;
    logic [15:0] e_lo, e_hi, e_res;
    logic        e_found;
    logic [1:0]  dly;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  6'd10, 6'd30, 6'd1,  6'd0,  16'd10,    16'd30,    16'd20,    1'b1, 2'd0},
    '{1'b0, 6'd0,  6'd1,  6'd0,  6'd1,  6'd0,  16'hFFFF,  16'hFFFF,  16'hFFFF,  1'b0, 2'd1},
    '{1'b0, 6'd0,  6'd5,  6'd9,  6'd40, 6'd50, 16'd5,     16'd50,    16'd27,    1'b1, 2'd2},
    '{1'b0, 6'd0,  6'd0,  6'd63, 6'd1,  6'd0,  16'd0,     16'd63,    16'd31,    1'b1, 2'd0},
    '{1'b0, 6'd0,  6'd63, 6'd63, 6'd1,  6'd0,  16'd63,    16'd63,    16'd63,    1'b1, 2'd0},
    '{1'b1, 6'd32, 6'd20, 6'd40, 6'd1,  6'd0,  16'd20,    16'd40,    16'd30,    1'b1, 2'd1},
    '{1'b1, 6'd3,  6'd0,  6'd10, 6'd1,  6'd0,  16'd0,     16'd10,    16'd5,     1'b1, 2'd0},
    '{1'b1, 6'd60, 6'd50, 6'd63, 6'd1,  6'd0,  16'd50,    16'd63,    16'd56,    1'b1, 2'd0},
    '{1'b1, 6'd30, 6'd25, 6'd35, 6'd40, 6'd45, 16'd25,    16'd35,    16'd30,    1'b1, 2'd3},
    '{1'b1, 6'd12, 6'd1,  6'd0,  6'd1,  6'd0,  16'd12,    16'd12,    16'd12,    1'b1, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_mask(input vec_t v);
    logic [63:0] m;
    for (int i = 0; i < 64; i++)
      m[i] = (i >= int'(v.a_lo) && i <= int'(v.a_hi)) || (i >= int'(v.b_lo) && i <= int'(v.b_hi));
    return m;
  endfunction

  // number of codes the search should request, from the requirements
  function automatic int exp_tests(input vec_t v, input logic [63:0] m);
    int n = 0;
    int c;
    if (!v.md) return 64;
    c = int'(v.med);
    forever begin
      n++;
      if (!m[c] || c == 63) break;
      c++;
    end
    c = int'(v.med);
    forever begin
      n++;
      if (!m[c] || c == 0) break;
      c--;
    end
    return n;
  endfunction

  task automatic run(input vec_t v, input bit poke);
    logic [63:0] m = mk_mask(v);
    int   n = 0;
    bit   ord_ok = 1'b1;
    bit   hold_ok = 1'b1;
    logic [5:0] c;
    logic [15:0] res_snap;
    @(negedge clk);
    mode = v.md; median = v.med; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      @(negedge clk);
      if (done) break;
      if (apply_req) begin
        c = apply_code;
        n++;
        if (!v.md && c != 6'(n - 1)) ord_ok = 1'b0;
        if (poke && n == 3) begin
          start = 1'b1; mode = ~v.md; median = 6'd7;
          @(negedge clk);
          start = 1'b0; mode = v.md; median = v.med;
          if (!apply_req || apply_code != c) hold_ok = 1'b0;
        end
        for (int k = 0; k < int'(v.dly); k++) begin
          @(negedge clk);
          if (!apply_req || apply_code != c) hold_ok = 1'b0;
        end
        apply_ack = 1'b1;
        @(negedge clk);
        apply_ack = 1'b0;
        if (apply_req) hold_ok = 1'b0;
        test_pass = m[c]; test_done = 1'b1;
        @(negedge clk);
        test_done = 1'b0; test_pass = 1'b0;
      end
    end
    chk(n == exp_tests(v, m), v.md ? "R6 request count" : "R2 request count", 64'(n), 64'(exp_tests(v, m)));
    if (!v.md) chk(ord_ok, "R2 ascending order", 64'(ord_ok), 64'd1);
    chk(hold_ok, "R8 request hold and drop", 64'(hold_ok), 64'd1);
    chk(win_lo == v.e_lo, v.md ? "R6 low bound" : "R3 low bound", 64'(win_lo), 64'(v.e_lo));
    chk(win_hi == v.e_hi, v.md ? "R5 high bound" : "R3 high bound", 64'(win_hi), 64'(v.e_hi));
    chk(found == v.e_found, v.e_found ? "R7 found flag" : "R4 found flag", 64'(found), 64'(v.e_found));
    chk(result == v.e_res, v.e_found ? "R7 result" : "R4 result", 64'(result), 64'(v.e_res));
    res_snap = result;
    @(negedge clk);
    chk(!done && result == res_snap, "R9 single done pulse, result held", {done, 16'(result)}, {1'b0, res_snap});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1-chain: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!apply_req && !done && !found, "R1 reset control outputs", {apply_req, done, found}, 3'b000);
    chk(result == 16'hFFFF && win_lo == 16'hFFFF && win_hi == 16'hFFFF,
        "R1 reset sentinels", {result, win_lo, win_hi}, {3{16'hFFFF}});

    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

    // R10: start while busy is ignored
    run(VECS[0], 1'b1);
    chk(result == 16'd20, "R10 busy start ignored", 64'(result), 64'd20);

    // R1: reset in the middle of a sweep
    @(negedge clk);
    mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      apply_ack = 1'b1;
      @(negedge clk);
      apply_ack = 1'b0; test_pass = 1'b1; test_done = 1'b1;
      @(negedge clk);
      test_done = 1'b0; test_pass = 1'b0;
    end
    @(negedge clk);
    chk(win_lo == 16'd0 && win_hi == 16'd1 && apply_req, "R3 partial sweep bounds",
        {win_lo, win_hi}, {16'd0, 16'd1});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!apply_req && !done && win_lo == 16'hFFFF && win_hi == 16'hFFFF,
        "R1 mid-search reset", {apply_req, done, win_lo, win_hi}, {2'b00, 32'hFFFFFFFF});
    repeat (3) @(negedge clk);
    chk(!apply_req, "R1 idle after reset", 64'(apply_req), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule